// File: doc/BRIEF.md
# Two-Master Bus Arbiter with Starvation Override

This block decides which of two bus masters drives one shared target bus. One master is the main processor and the other is a debug agent with lower priority. Each master raises a request. The arbiter answers with a registered grant and drives a select line that steers the target multiplexer. The processor also pulses an operation-done signal at the end of each bus operation.

When both masters compete, the processor normally wins. A saturating stall timer counts the consecutive cycles in which the debug agent requests the bus but does not hold it. If that stall exceeds a configurable limit (128 cycles by default), the debug agent is promoted. The processor keeps the bus until its current operation ends. On the cycle after the processor's done pulse, the bus moves to the debug agent. The debug agent then holds the bus until it withdraws its request.

Top module: `dual_master_arbiter`

## Requirements
- R1: While the synchronous active-high reset is high, and after it, until a request arrives, both grants and the select line are 0.
- R2: The processor grant and the debug grant are never high in the same cycle.
- R3: A master that requests while the bus is idle and the other master is not requesting is granted after the next rising clock edge, whatever its priority.
- R4: When both masters request from idle and the debug agent is not promoted, the processor is granted.
- R5: A granted processor keeps the bus for as long as its request stays high, unless a promotion hand-off (R7) occurs.
- R6: The stall timer counts only cycles with the debug request high and the debug grant low, and it clears when either condition fails. After exactly 128 stall cycles, a processor done pulse leaves the bus with the processor.
- R7: After more than 128 stall cycles, a processor done pulse hands the bus over on the next edge. The processor grant falls and the debug grant rises in the same cycle.
- R8: While the debug agent is promoted, the processor grant stays high for as long as the processor requests and no done pulse arrives.
- R9: A granted debug agent keeps the bus until it drops its request. The processor, if requesting, is then granted on the next edge. The stall timer restarts from zero.
- R10: The select line is 1 exactly when the debug agent holds the grant, and 0 otherwise.
- R11: The stall timer saturates, so a stall of 300 cycles still promotes the debug agent and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor requests the bus |
| cpu_done | input | 1 | One-cycle pulse: processor finished its current operation |
| dbg_req | input | 1 | Debug agent requests the bus |
| cpu_gnt | output | 1 | Processor owns the bus |
| dbg_gnt | output | 1 | Debug agent owns the bus |
| tgt_sel | output | 1 | Target multiplexer select: 0 processor, 1 debug agent |

## Verification
A vector table exercises single requesters, simultaneous requests from idle, release-to-waiting-master hand-offs in both directions, and done pulses that must not move the bus. Together these separate plain fixed priority from ownership retention. Directed runs hold the debug request against a busy processor for exactly 128 cycles and then for one more. This shows where promotion starts and that the hand-off waits for the done pulse. A 300-cycle stall separates a saturating timer from a wrapping one. A second 128-cycle stall after a debug tenure confirms that the timer restarts. A reset during a processor tenure confirms that grants clear.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_CPU  = 2'd1,
        OWN_DBG  = 2'd2
    } owner_e;

    typedef struct packed {
        owner_e owner;
    } owner_state_t;

endpackage

// File: rtl/arb_stall_timer.sv
module arb_stall_timer #(
    parameter int STALL_LIMIT = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic dbg_req,
    input  logic dbg_gnt,
    output logic promote
);
    localparam int CW = $clog2(STALL_LIMIT + 2);
    localparam logic [CW-1:0] SAT_V = CW'(STALL_LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } timer_t;

    timer_t tmr_d, tmr_q;
    logic   stalled;

    always_comb begin
        tmr_d   = tmr_q;
        stalled = dbg_req && !dbg_gnt;
        if (!stalled) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt != SAT_V) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tmr_q <= '0;
        else     tmr_q <= tmr_d;
    end

    assign promote = (tmr_q.cnt == SAT_V);

    AST_TIMER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!dbg_req || dbg_gnt) |=> (tmr_q.cnt == '0)); // R6

    AST_TIMER_SAT: assert property (@(posedge clk) disable iff (rst)
        (promote && dbg_req && !dbg_gnt) |=> promote); // R11

endmodule

// File: rtl/arb_owner_fsm.sv
module arb_owner_fsm
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cpu_req,
    input  logic cpu_done,
    input  logic dbg_req,
    input  logic promote,
    output logic cpu_gnt,
    output logic dbg_gnt,
    output logic tgt_sel
);
    owner_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.owner)
            OWN_NONE: begin
                if (dbg_req && (promote || !cpu_req)) st_d.owner = OWN_DBG;
                else if (cpu_req)                     st_d.owner = OWN_CPU;
            end
            OWN_CPU: begin
                if (!cpu_req) begin
                    st_d.owner = dbg_req ? OWN_DBG : OWN_NONE;
                end else if (cpu_done && promote && dbg_req) begin
                    st_d.owner = OWN_DBG;
                end
            end
            OWN_DBG: begin
                if (!dbg_req) begin
                    st_d.owner = cpu_req ? OWN_CPU : OWN_NONE;
                end
            end
            default: st_d.owner = OWN_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{owner: OWN_NONE};
        else     st_q <= st_d;
    end

    assign cpu_gnt = (st_q.owner == OWN_CPU);
    assign dbg_gnt = (st_q.owner == OWN_DBG);
    assign tgt_sel = dbg_gnt;

    AST_DBG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dbg_gnt && dbg_req) |=> dbg_gnt); // R9

    AST_CPU_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cpu_gnt && cpu_req && !cpu_done) |=> cpu_gnt); // R8

endmodule

// File: rtl/dual_master_arbiter.sv
module dual_master_arbiter #(
    parameter int STALL_LIMIT = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic cpu_req,
    input  logic cpu_done,
    input  logic dbg_req,
    output logic cpu_gnt,
    output logic dbg_gnt,
    output logic tgt_sel
);
    logic promote;

    arb_stall_timer #(.STALL_LIMIT(STALL_LIMIT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .dbg_req (dbg_req),
        .dbg_gnt (dbg_gnt),
        .promote (promote)
    );

    arb_owner_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .cpu_req  (cpu_req),
        .cpu_done (cpu_done),
        .dbg_req  (dbg_req),
        .promote  (promote),
        .cpu_gnt  (cpu_gnt),
        .dbg_gnt  (dbg_gnt),
        .tgt_sel  (tgt_sel)
    );

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
        !(cpu_gnt && dbg_gnt)); // R2

    AST_HANDOFF: assert property (@(posedge clk) disable iff (rst)
        (cpu_gnt && cpu_req && cpu_done && promote && dbg_req) |=> (dbg_gnt && !cpu_gnt)); // R7

    AST_LONE_DBG: assert property (@(posedge clk) disable iff (rst)
        (!cpu_gnt && !dbg_gnt && !cpu_req && dbg_req) |=> dbg_gnt); // R3

    AST_SEL_OWNER: assert property (@(posedge clk) disable iff (rst)
        (tgt_sel == dbg_gnt) && !(tgt_sel && cpu_gnt)); // R10

endmodule

// File: tb/sim_dual_master_arbiter.sv
`timescale 1ns/1ps
module sim_dual_master_arbiter;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_req = 1'b0, cpu_done = 1'b0, dbg_req = 1'b0;
    logic cpu_gnt, dbg_gnt, tgt_sel;
    int   n_run = 0;
    int   n_fail = 0;

    always #5 clk = ~clk;

    dual_master_arbiter u0 (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_done(cpu_done),
        .dbg_req(dbg_req), .cpu_gnt(cpu_gnt), .dbg_gnt(dbg_gnt), .tgt_sel(tgt_sel)
    );

    // bits: [4] cpu_req [3] cpu_done [2] dbg_req [1] expected cpu_gnt [0] expected dbg_gnt
    localparam logic [4:0] VEC [12] = '{
        5'b000_00,  // R1 idle stays idle
        5'b100_10,  // R3 lone processor
        5'b101_10,  // R5 processor keeps the bus
        5'b111_10,  // R6 done without promotion keeps processor
        5'b001_01,  // R9 processor releases to waiting debug
        5'b101_01,  // R9 debug keeps the bus
        5'b100_10,  // R9 debug drops, processor next
        5'b000_00,
        5'b101_10,  // R4 simultaneous from idle
        5'b000_00,
        5'b001_01,  // R3 lone debug
        5'b000_00
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [2:0] exp);
        logic [2:0] act;
        act = {cpu_gnt, dbg_gnt, tgt_sel};
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {cpu_gnt,dbg_gnt,tgt_sel} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic done_pulse();
        cpu_done = 1'b1;
        tick();
        cpu_done = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst && cpu_gnt && dbg_gnt) begin
            n_fail++;
            $display("FAIL R2: both grants high actual=11 expected=not 11");
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        check("R1 during reset", 3'b000);
        rst = 1'b0;
        tick();
        check("R1 after reset", 3'b000);

        foreach (VEC[i]) begin
            cpu_req  = VEC[i][4];
            cpu_done = VEC[i][3];
            dbg_req  = VEC[i][2];
            tick();
            check($sformatf("R10 vector %0d", i), {VEC[i][1], VEC[i][0], VEC[i][0]});
        end
        cpu_done = 1'b0;

        // R6 / R7 / R8: boundary of the stall limit
        cpu_req = 1'b1; dbg_req = 1'b0;
        tick();
        check("R3 processor owns", 3'b100);
        dbg_req = 1'b1;
        repeat (128) tick();
        check("R8 stall of 128, no done", 3'b100);
        done_pulse();
        check("R6 done at 128 stall keeps processor", 3'b100);
        repeat (20) tick();
        check("R8 promoted but no done", 3'b100);
        done_pulse();
        check("R7 hand-off after done", 3'b011);
        repeat (5) tick();
        check("R9 debug holds while processor waits", 3'b011);
        dbg_req = 1'b0;
        tick();
        check("R9 processor after debug release", 3'b100);

        // R9: timer restarted after debug tenure
        dbg_req = 1'b1;
        repeat (128) tick();
        done_pulse();
        check("R9 timer restarted, 128 stall no promotion", 3'b100);
        dbg_req = 1'b0;
        tick();

        // R11: long stall must not wrap
        dbg_req = 1'b1;
        repeat (300) tick();
        check("R8 long stall no done", 3'b100);
        done_pulse();
        check("R11 saturated timer promotes", 3'b011);
        dbg_req = 1'b0; cpu_req = 1'b0;
        tick();
        check("R1 back to idle", 3'b000);

        // R1: reset during processor tenure
        cpu_req = 1'b1; dbg_req = 1'b1;
        tick();
        check("R4 processor wins", 3'b100);
        rst = 1'b1;
        tick();
        check("R1 reset clears grant", 3'b000);
        rst = 1'b0; cpu_req = 1'b0; dbg_req = 1'b0;
        tick();
        check("R1 idle after reset", 3'b000);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule